// File: doc/BRIEF.md
# One-Dimensional Pong Ball Controller

This block runs a one-lane ball game on a row of indicator outputs. At most one output is lit, marking the ball. On each cycle where the game tick is high, the lit position moves one place in the current direction of travel. A flip-flop holds that direction and selects whether the row shifts up or down. The player has a single paddle input. A press sends the ball back only if the ball is sitting on the last position before the end it is heading toward. If the ball is not returned, it shifts off the row and every output goes dark.

A serve request puts a new ball at position 0, travelling upward. The request is accepted only while no output is lit. All inputs are plain control pins. No data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pong_lane`

## Requirements
- R1: At most one bit of `lanes` is high at any time.
- R2: While `rst_n` is low, `lanes` is all zero and `dir_up` is 1. `dir_up` = 1 means travel toward higher bit indices.
- R3: A clock edge with `serve` high while `lanes` is all zero sets `lanes` to bit 0 only and `dir_up` to 1.
- R4: `serve` has no effect while any bit of `lanes` is high.
- R5: At a clock edge with `tick` high, the lit bit moves one index up (if `dir_up` is 1) or down (if `dir_up` is 0). With `tick` low and no serve accepted, `lanes` holds.
- R6: If a tick shifts the ball beyond bit LANES-1 while travelling up, or below bit 0 while travelling down, `lanes` becomes all zero.
- R7: `paddle` passes through two synchronizing flip-flops, and only its rising edge counts. A `paddle` first sampled high at clock edge k flips `dir_up` at edge k+2, when the ball is at the end it is travelling toward. Holding `paddle` high flips the direction only once.
- R8: A paddle rising edge has no effect on `dir_up` unless the ball is at the end bit it is travelling toward: bit LANES-1 when travelling up, bit 0 when travelling down.
- R9: When a paddle reversal and a tick occur at the same edge, the ball moves one place in the new direction at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Game step enable |
| paddle | input | 1 | Player paddle, asynchronous |
| serve | input | 1 | Request to put a new ball in play |
| lanes | output | LANES | Ball position, at most one bit high |
| dir_up | output | 1 | Current direction, 1 = toward higher index |

## Verification
The assertions assume that `tick` and `serve` are synchronous to `clk`. They also assume the paddle edge detector starts from a low, settled paddle after reset. The stimulus changes every input only on the falling clock edge, and it keeps `paddle` low during reset.

The bench has a cycle model that follows the two-stage paddle delay. It covers these cases:
- paddle presses in mid-row, which must be ignored;
- presses at both ends;
- a press whose reversal lands on a tick cycle;
- a ball left unreturned, so that it shifts off each end of the row.

// File: rtl/pong_pkg.sv
package pong_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/paddle_sync.sv
module paddle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic paddle_raw,
  output logic press
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], paddle_raw};
      last_q  <= chain_q[LAST];
    end
  end

  assign press = chain_q[LAST] & ~last_q;

  // R7
  press_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press);
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import pong_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic press,
  input  logic at_end,
  input  logic load,
  output dir_e dir_q,
  output dir_e dir_next
);
  logic hit;

  assign hit      = press & at_end;
  assign dir_next = load ? DIR_UP : dir_e'(dir_q ^ hit);

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= DIR_UP;
    else        dir_q <= dir_next;
  end

  // R7
  hit_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load) |=> (dir_q != $past(dir_q)));
  // R8
  no_hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !load) |=> $stable(dir_q));
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import pong_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  dir_e             dir_next,
  output logic [LANES-1:0] lanes,
  output logic             empty,
  output logic             at_hi,
  output logic             at_lo
);
  localparam int TOP = LANES - 1;

  logic [LANES-1:0] shifted;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic from_below, from_above;
    if (i == 0) begin : g_bot
      assign from_below = 1'b0;
    end else begin : g_bot
      assign from_below = lanes[i-1];
    end
    if (i == TOP) begin : g_top
      assign from_above = 1'b0;
    end else begin : g_top
      assign from_above = lanes[i+1];
    end
    assign shifted[i] = (dir_next == DIR_UP) ? from_below : from_above;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    lanes <= '0;
    else if (load) lanes <= LANES'(1);
    else if (tick) lanes <= shifted;
  end

  assign empty = (lanes == '0);
  assign at_hi = lanes[TOP];
  assign at_lo = lanes[0];

  // R1
  one_ball_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lanes));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(lanes));
  // R3
  serve_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lanes == LANES'(1)));
  // R6
  fall_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_hi && dir_next == DIR_UP) |=> (lanes == '0));
  // R6
  fall_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_lo && dir_next == DIR_DOWN) |=> (lanes == '0));
endmodule

// File: rtl/pong_lane.sv
module pong_lane
  import pong_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             paddle,
  input  logic             serve,
  output logic [LANES-1:0] lanes,
  output logic             dir_up
);
  logic press, empty, at_hi, at_lo, at_end, load;
  dir_e dir_q, dir_next;

  assign load   = serve & empty;
  assign at_end = (dir_q == DIR_UP) ? at_hi : at_lo;
  assign dir_up = (dir_q == DIR_UP);

  paddle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .paddle_raw(paddle), .press(press)
  );

  dir_ctrl u_dir (
    .clk(clk), .rst_n(rst_n), .press(press), .at_end(at_end),
    .load(load), .dir_q(dir_q), .dir_next(dir_next)
  );

  lane_shifter #(.LANES(LANES)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .dir_next(dir_next), .lanes(lanes), .empty(empty),
    .at_hi(at_hi), .at_lo(at_lo)
  );

  // R4
  serve_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serve && !empty && !tick) |=> $stable(lanes));
endmodule

// File: tb/tb_pong_lane.sv
module tb_pong_lane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, paddle = 1'b0, serve = 1'b0;
  logic [7:0] lanes;
  logic dir_up;
  int total = 0, bad = 0;
  bit done = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] m_l;
  logic m_d, s0, s1, pv;

  always #2.5 clk = ~clk;

  pong_lane dut (.clk(clk), .rst_n(rst_n), .tick(tick), .paddle(paddle),
                 .serve(serve), .lanes(lanes), .dir_up(dir_up));

  task automatic cyc(input logic t, input logic s, input logic p, input string tag);
    logic hit, nd;
    logic [7:0] nl;
    @(negedge clk);
    tick = t; serve = s; paddle = p;
    hit = s1 & ~pv & (m_d ? m_l[7] : m_l[0]);
    if (m_l == 8'h00 && s) begin
      nl = 8'h01; nd = 1'b1;
    end else begin
      nd = m_d ^ hit;
      nl = t ? (nd ? (m_l << 1) : (m_l >> 1)) : m_l;
    end
    pv = s1; s1 = s0; s0 = p;
    m_l = nl; m_d = nd;
    exp_q.push_back({nd, nl});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    logic [8:0] e;
    string tg;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        total++;
        if ({dir_up, lanes} !== e) begin
          bad++;
          $display("FAIL %s: got dir=%b lanes=%b expected dir=%b lanes=%b",
                   tg, dir_up, lanes, e[8], e[7:0]);
        end
        total++;
        if ($countones(lanes) > 1) begin
          bad++;
          $display("FAIL R1: got lanes=%b expected at most one bit", lanes);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    m_l = 8'h00; m_d = 1'b1; s0 = 1'b0; s1 = 1'b0; pv = 1'b0;
    repeat (4) @(negedge clk);
    total++;
    if (lanes !== 8'h00 || dir_up !== 1'b1) begin
      bad++;
      $display("FAIL R2: got dir=%b lanes=%b expected dir=1 lanes=00000000", dir_up, lanes);
    end
    rst_n = 1'b1;
    repeat (2) cyc(1, 0, 0, "R5");
    cyc(0, 1, 0, "R3");
    cyc(0, 1, 0, "R4");
    cyc(1, 1, 0, "R4");
    repeat (2) cyc(1, 0, 0, "R5");
    repeat (4) cyc(0, 0, 1, "R8");
    repeat (3) cyc(0, 0, 0, "R8");
    repeat (4) cyc(1, 0, 0, "R5");
    repeat (5) cyc(0, 0, 1, "R7");
    repeat (2) cyc(0, 0, 0, "R7");
    repeat (7) cyc(1, 0, 0, "R5");
    cyc(0, 0, 1, "R9");
    cyc(0, 0, 1, "R9");
    cyc(1, 0, 1, "R9");
    repeat (2) cyc(0, 0, 0, "R9");
    repeat (6) cyc(1, 0, 0, "R5");
    cyc(1, 0, 0, "R6");
    cyc(1, 0, 0, "R6");
    cyc(0, 1, 0, "R3");
    repeat (7) cyc(1, 0, 0, "R5");
    repeat (3) cyc(0, 0, 1, "R7");
    repeat (2) cyc(0, 0, 0, "R7");
    repeat (7) cyc(1, 0, 0, "R5");
    cyc(1, 0, 0, "R6");
    cyc(1, 1, 0, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule